// File: doc/BRIEF.md
# EDO DRAM Device Control Model

This block models the control side of a 16-bit-wide EDO page-mode DRAM. It is meant to stand in for the memory when a DRAM controller is under test. On every edge of a fast system clock it samples the row strobe, the two byte-lane column strobes, write enable, output enable and the 9-bit multiplexed address. From the order in which these pins change it works out which cycle the controller is running: read, early write, late write, read-modify-write, RAS-only refresh, CAS-before-RAS refresh or hidden refresh. A small parameterised array holds the data. Only the low bits of the row and column index the array.

The block keeps its own 9-bit refresh row counter. It drives read data with one enable per byte lane, and it keeps that data on the bus after the column strobe rises, as EDO parts do. A debug group of pins shows the decoded cycle code, the counter and the last row refreshed, so a bench can see them. The strobe and data pins are plain levels and have no handshake: the controller under test sets their timing, and the model reacts to the level it samples at each clock edge.

Every effect shows at the outputs after the first clock edge at which the new pin level is sampled.

Top module: `edo_dram_model`

## Requirements
- R1: After reset, `dout_en` is 0, `dbg_cycle` is 0 (idle) and `dbg_rcnt` is 0.
- R2: Byte lane 0 (`dout_en[0]`, data bits 7:0) belongs to `lcas_n`, and byte lane 1 (`dout_en[1]`, bits 15:8) belongs to `ucas_n`. The internal column event starts when the first strobe falls. A lane whose strobe falls later in the same read joins the driven set.
- R3: If either column strobe was low at the sample before `ras_n` falls, the cycle is a CAS-before-RAS refresh, with cycle code 6. `dbg_ref_row` takes the counter value and the counter then advances by one, wrapping modulo 512. The address is ignored and no output is driven.
- R4: A fall of `ras_n` with both column strobes high latches the row from `addr`. It gives cycle code 5 (RAS-only refresh) and sets `dbg_ref_row` to `addr`. The counter does not change.
- R5: If `we_n` is low at a column fall inside a row cycle, the cycle is an early write, with code 5 replaced by code 2. Only the lanes whose strobe is low are written. The outputs stay off for the rest of the cycle.
- R6: A fall of `we_n` while a read holds the column strobe low writes `din` into the lanes that are low. The cycle code is 4 (read-modify-write) if `oe_n` was low at any sample since the column fall, and 3 (late write) otherwise. `dout` keeps the word read before the write.
- R7: Read data stays on `dout` and stays enabled after the column strobes rise while `ras_n` is low. `dout` changes only at a column fall.
- R8: `dout_en` is 0 while `oe_n` is high or `we_n` is low. Read data is dropped once `ras_n` and both column strobes are sampled high.
- R9: If `ras_n` rises and falls again while a column strobe stays low after a read, the cycle is a hidden refresh, with code 7. The counter advances and the previous read data stays driven.
- R10: A read or write cycle refreshes its own row: `dbg_ref_row` holds the row latched at the `ras_n` fall.
- R11: If `we_n` is high at a column fall inside a row cycle, the cycle is a read, with code 1. `dout` then shows the array word at {row[2:0], col[2:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system sampling clock |
| rst_n | input | 1 | active-low synchronous reset |
| ras_n | input | 1 | row strobe, active low |
| lcas_n | input | 1 | lower-byte column strobe, active low |
| ucas_n | input | 1 | upper-byte column strobe, active low |
| we_n | input | 1 | write enable, active low |
| oe_n | input | 1 | output enable, active low |
| addr | input | 9 | multiplexed row/column address |
| din | input | 16 | write data |
| dout | output | 16 | held read data |
| dout_en | output | 2 | per-lane output drive enable |
| dbg_cycle | output | 3 | decoded cycle code |
| dbg_rcnt | output | 9 | internal refresh row counter |
| dbg_ref_row | output | 9 | last row refreshed |

## Verification
Two functions can act in the same clock: a refresh, which advances the counter, and the EDO hold of read data on the bus. The bench provokes this as a hidden refresh. It reads a word, raises `ras_n` with both column strobes still low, and then lowers `ras_n` again. In the clock where the refresh is decoded, the behavioural model expects four things together: cycle code 7, the counter one higher, `dbg_ref_row` equal to the old counter value, and the read word still enabled on both lanes. A plain CAS-before-RAS refresh with no data held must leave `dout_en` at 0, and the bench checks this to set the two cases apart.

// File: rtl/edo_dram_pkg.sv
package edo_dram_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE     = 3'd0,
    CYC_READ     = 3'd1,
    CYC_EARLY_WR = 3'd2,
    CYC_LATE_WR  = 3'd3,
    CYC_RMW      = 3'd4,
    CYC_RAS_ONLY = 3'd5,
    CYC_CBR      = 3'd6,
    CYC_HIDDEN   = 3'd7
  } cyc_e;
endpackage

// File: rtl/edo_strobe_edges.sv
module edo_strobe_edges #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  output logic             ras_fall,
  output logic             ras_rise,
  output logic             cas_fall,
  output logic             cas_low_prev,
  output logic             we_fall,
  output logic [LANES-1:0] lane_fall
);
  logic             ras_q;
  logic             we_q;
  logic [LANES-1:0] cas_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      we_q  <= 1'b1;
      cas_q <= '1;
    end else begin
      ras_q <= ras_n;
      we_q  <= we_n;
      cas_q <= cas_n;
    end
  end

  assign ras_fall     = ras_q & ~ras_n;
  assign ras_rise     = ~ras_q & ras_n;
  assign we_fall      = we_q & ~we_n;
  assign cas_low_prev = ~&cas_q;
  assign cas_fall     = (~&cas_n) & ~cas_low_prev;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_fall[g] = cas_q[g] & ~cas_n[g];
  end
endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int IDX_W  = 6,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_en,
  input  logic [IDX_W-1:0]        widx,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [IDX_W-1:0]        ridx,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en[g]) bank[widx] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = bank[ridx];
  end
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
  import edo_dram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  parameter int RIDX_W = 3,
  parameter int CIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [1:0]        dout_en,
  output logic [2:0]        dbg_cycle,
  output logic [ADDR_W-1:0] dbg_rcnt,
  output logic [ADDR_W-1:0] dbg_ref_row
);
  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;
  localparam int IDX_W  = RIDX_W + CIDX_W;

  logic [LANES-1:0]  cas_n_v;
  logic [LANES-1:0]  lane_on;
  logic              cas_low;
  logic              ras_fall, ras_rise, cas_fall, cas_low_prev, we_fall;
  logic [LANES-1:0]  lane_fall;

  assign cas_n_v = {ucas_n, lcas_n};
  assign lane_on = ~cas_n_v;
  assign cas_low = |lane_on;

  edo_strobe_edges #(.LANES(LANES)) u_edges (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n_v), .we_n(we_n),
    .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall),
    .cas_low_prev(cas_low_prev), .we_fall(we_fall), .lane_fall(lane_fall)
  );

  // row-cycle state
  logic              acc_ok;
  logic [RIDX_W-1:0] row_q;
  logic [CIDX_W-1:0] col_q;
  logic              dv_q;
  logic [LANES-1:0]  lane_sel;
  logic              seen_oe;
  cyc_e              cyc_q;
  logic [DATA_W-1:0] dout_q;
  logic [ADDR_W-1:0] ref_row;

  // decoded events
  logic cbr_start, acc_fall, early_wr, rd_hit, late_wr;
  assign cbr_start = ras_fall & cas_low_prev;
  assign acc_fall  = cas_fall & acc_ok;
  assign early_wr  = acc_fall & ~we_n;
  assign rd_hit    = acc_fall & we_n;
  assign late_wr   = we_fall & cas_low & ~cas_fall & acc_ok & (cyc_q == CYC_READ);

  logic [LANES-1:0]  wr_en;
  logic [IDX_W-1:0]  widx, ridx;
  logic [DATA_W-1:0] rdata;
  logic [ADDR_W-1:0] rcnt;

  assign wr_en = (early_wr | late_wr) ? lane_on : '0;
  assign widx  = early_wr ? {row_q, addr[CIDX_W-1:0]} : {row_q, col_q};
  assign ridx  = {row_q, addr[CIDX_W-1:0]};

  edo_cell_array #(.IDX_W(IDX_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .wr_en(wr_en), .widx(widx), .wdata(din), .ridx(ridx), .rdata(rdata)
  );

  edo_refresh_ctr #(.W(ADDR_W)) u_rctr (
    .clk(clk), .rst_n(rst_n), .adv(cbr_start), .cnt(rcnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_ok   <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      dv_q     <= 1'b0;
      lane_sel <= '0;
      seen_oe  <= 1'b0;
      cyc_q    <= CYC_IDLE;
      dout_q   <= '0;
      ref_row  <= '0;
    end else begin
      if (ras_fall) begin
        if (cas_low_prev) begin
          acc_ok  <= 1'b0;
          ref_row <= rcnt;
          cyc_q   <= dv_q ? CYC_HIDDEN : CYC_CBR;
        end else begin
          acc_ok  <= 1'b1;
          row_q   <= addr[RIDX_W-1:0];
          ref_row <= addr;
          cyc_q   <= CYC_RAS_ONLY;
        end
      end else if (ras_rise) begin
        acc_ok <= 1'b0;
      end

      if (cyc_q == CYC_READ && !oe_n) seen_oe <= 1'b1;

      if (rd_hit) begin
        dout_q   <= rdata;
        dv_q     <= 1'b1;
        lane_sel <= lane_on;
        col_q    <= addr[CIDX_W-1:0];
        seen_oe  <= ~oe_n;
        cyc_q    <= CYC_READ;
      end else if (early_wr) begin
        col_q <= addr[CIDX_W-1:0];
        dv_q  <= 1'b0;
        cyc_q <= CYC_EARLY_WR;
      end else if (late_wr) begin
        cyc_q <= (seen_oe | ~oe_n) ? CYC_RMW : CYC_LATE_WR;
      end else if (acc_ok && cas_low_prev && cyc_q == CYC_READ && |lane_fall) begin
        lane_sel <= lane_sel | lane_fall;
      end

      if (ras_n && !cas_low) dv_q <= 1'b0;
    end
  end

  assign dout        = dout_q;
  assign dout_en     = (dv_q & ~oe_n & we_n) ? lane_sel : '0;
  assign dbg_cycle   = cyc_q;
  assign dbg_rcnt    = rcnt;
  assign dbg_ref_row = ref_row;
endmodule

// File: rtl/edo_dram_checks.sv
module edo_dram_checks #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              lcas_n,
  input logic              ucas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dout,
  input logic [1:0]        dout_en,
  input logic [2:0]        dbg_cycle,
  input logic [ADDR_W-1:0] dbg_rcnt,
  input logic [ADDR_W-1:0] dbg_ref_row
);
  logic cas_low, cas_low_q, ras_q;
  assign cas_low = !lcas_n || !ucas_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cas_low_q <= 1'b0;
      ras_q     <= 1'b1;
    end else begin
      cas_low_q <= cas_low;
      ras_q     <= ras_n;
    end
  end

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en != 2'b00) |-> (!oe_n && we_n));

  assert_idle_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && lcas_n && ucas_n) |=> (dout_en == 2'b00));

  assert_cbr_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_q && !ras_n && cas_low_q) |=> (dbg_rcnt == $past(dbg_rcnt) + 1'b1));

  assert_cbr_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_cycle == 3'd6) |-> (dout_en == 2'b00));

  assert_ras_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_q && !ras_n && !cas_low_q) |=> (dbg_ref_row == $past(addr) && $stable(dbg_rcnt)));

  assert_early_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_cycle == 3'd2) |-> (dout_en == 2'b00));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cas_low && !cas_low_q) |=> $stable(dout));
endmodule

bind edo_dram_model edo_dram_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
  .we_n(we_n), .oe_n(oe_n), .addr(addr), .dout(dout), .dout_en(dout_en),
  .dbg_cycle(dbg_cycle), .dbg_rcnt(dbg_rcnt), .dbg_ref_row(dbg_ref_row)
);

// File: tb/edo_dram_model_bench.sv
`timescale 1ns/1ps
module edo_dram_model_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  dout_en;
  logic [2:0]  dbg_cycle;
  logic [8:0]  dbg_rcnt, dbg_ref_row;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  edo_dram_model u_edo_dram_model (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .dbg_cycle(dbg_cycle), .dbg_rcnt(dbg_rcnt),
    .dbg_ref_row(dbg_ref_row)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [15:0] mem [int];
  bit   p_ras, p_cas, p_we, p_l, p_u;
  bit   m_acc, m_dv, m_seen;
  int   m_row, m_col, m_cyc, m_rcnt, m_ref;
  logic [1:0]  m_sel;
  logic [15:0] m_dout;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_ras = 1; p_cas = 0; p_we = 1; p_l = 1; p_u = 1;
      m_acc = 0; m_dv = 0; m_seen = 0; m_row = 0; m_col = 0;
      m_cyc = 0; m_rcnt = 0; m_ref = 0; m_sel = 0; m_dout = 0;
    end else begin
      bit c_low, o_acc, o_seen;
      int o_cyc, key;
      c_low  = !lcas_n || !ucas_n;
      o_acc  = m_acc;
      o_seen = m_seen;
      o_cyc  = m_cyc;
      if (p_ras && !ras_n) begin
        if (p_cas) begin
          m_acc = 0; m_ref = m_rcnt; m_cyc = m_dv ? 7 : 6;
          m_rcnt = (m_rcnt + 1) % 512;
        end else begin
          m_acc = 1; m_row = addr % 8; m_ref = addr; m_cyc = 5;
        end
      end else if (!p_ras && ras_n) m_acc = 0;
      if (o_cyc == 1 && !oe_n) m_seen = 1;
      if (c_low && !p_cas && o_acc) begin
        key = m_row * 8 + addr % 8;
        m_col = addr % 8;
        if (we_n) begin
          m_dout = mem.exists(key) ? mem[key] : 16'hxxxx;
          m_dv = 1; m_sel = {!ucas_n, !lcas_n}; m_seen = !oe_n; m_cyc = 1;
        end else begin
          logic [15:0] w;
          w = mem.exists(key) ? mem[key] : 16'h0000;
          if (!lcas_n) w[7:0]  = din[7:0];
          if (!ucas_n) w[15:8] = din[15:8];
          mem[key] = w;
          m_dv = 0; m_cyc = 2;
        end
      end else if (p_we && !we_n && c_low && o_acc && o_cyc == 1) begin
        logic [15:0] w;
        key = m_row * 8 + m_col;
        w = mem.exists(key) ? mem[key] : 16'h0000;
        if (!lcas_n) w[7:0]  = din[7:0];
        if (!ucas_n) w[15:8] = din[15:8];
        mem[key] = w;
        m_cyc = (o_seen || !oe_n) ? 4 : 3;
      end else if (o_acc && p_cas && o_cyc == 1) begin
        if (p_l && !lcas_n) m_sel[0] = 1'b1;
        if (p_u && !ucas_n) m_sel[1] = 1'b1;
      end
      if (ras_n && !c_low) m_dv = 0;
      p_ras = ras_n; p_cas = c_low; p_we = we_n; p_l = lcas_n; p_u = ucas_n;

      #3;
      begin
        logic [1:0] e_en;
        e_en = (m_dv && !oe_n && we_n) ? m_sel : 2'b00;
        chk("R8 model dout_en", dout_en, e_en);
        chk("R6 model cycle code", dbg_cycle, m_cyc);
        chk("R3 model refresh counter", dbg_rcnt, m_rcnt);
        chk("R10 model refreshed row", dbg_ref_row, m_ref);
        if (e_en != 0 && !$isunknown(m_dout)) chk("R11 model read data", dout, m_dout);
      end
    end
  end

  task automatic put(input logic r, input logic l, input logic u, input logic w,
                     input logic o, input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    ras_n = r; lcas_n = l; ucas_n = u; we_n = w; oe_n = o; addr = a; din = d;
    @(posedge clk);
    #4;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #4;
    chk("R1 reset dout_en", dout_en, 0);
    chk("R1 reset cycle", dbg_cycle, 0);
    chk("R1 reset counter", dbg_rcnt, 0);

    // early writes in page mode, row 2
    put(0,1,1,1,1,9'd2,0);
    chk("R4 ras fall code", dbg_cycle, 5);
    chk("R4 ras fall row", dbg_ref_row, 2);
    put(0,0,0,0,1,9'd5,16'hA5C3);
    chk("R5 early write code", dbg_cycle, 2);
    chk("R5 early write off", dout_en, 0);
    put(0,1,1,1,1,9'd5,0);
    chk("R5 stays off", dout_en, 0);
    put(0,0,0,0,1,9'd6,16'hFFFF);
    put(0,1,1,1,1,9'd6,0);
    put(0,1,0,0,1,9'd6,16'h1200);
    chk("R5 byte write code", dbg_cycle, 2);
    put(1,1,1,1,1,0,0);

    // page-mode read
    put(0,1,1,1,0,9'd2,0);
    put(0,0,0,1,0,9'd5,0);
    chk("R11 read code", dbg_cycle, 1);
    chk("R11 read data", dout, 16'hA5C3);
    chk("R11 read lanes", dout_en, 3);
    chk("R10 read row refreshed", dbg_ref_row, 2);
    put(0,1,1,1,0,9'd5,0);
    chk("R7 hold en", dout_en, 3);
    chk("R7 hold data", dout, 16'hA5C3);
    put(0,0,1,1,0,9'd6,0);
    chk("R2 lower lane only", dout_en, 1);
    chk("R5 upper byte written only", dout, 16'h12FF);
    put(0,0,1,1,1,9'd6,0);
    chk("R8 oe high off", dout_en, 0);
    put(0,0,1,1,0,9'd6,0);
    chk("R8 oe low back on", dout_en, 1);
    put(0,0,0,1,0,9'd6,0);
    chk("R2 late lane joins", dout_en, 3);
    put(0,1,1,1,0,9'd6,0);
    put(1,1,1,1,0,9'd6,0);
    chk("R8 both high off", dout_en, 0);

    // RAS-only refresh
    put(0,1,1,1,1,9'h1AB,0);
    chk("R4 ras-only code", dbg_cycle, 5);
    chk("R4 ras-only row", dbg_ref_row, 9'h1AB);
    chk("R4 counter unchanged", dbg_rcnt, 0);
    put(1,1,1,1,1,0,0);

    // CBR refresh
    put(1,0,1,1,0,9'h155,0);
    put(0,0,1,1,0,9'h155,0);
    chk("R3 cbr code", dbg_cycle, 6);
    chk("R3 cbr row from counter", dbg_ref_row, 0);
    chk("R3 cbr advance", dbg_rcnt, 1);
    chk("R3 cbr off", dout_en, 0);
    put(1,0,1,1,0,0,0);
    put(1,1,1,1,1,0,0);

    // hidden refresh
    put(0,1,1,1,0,9'd2,0);
    put(0,0,0,1,0,9'd5,0);
    put(1,0,0,1,0,9'd5,0);
    chk("R9 held across ras rise", dout_en, 3);
    put(0,0,0,1,0,9'd5,0);
    chk("R9 hidden code", dbg_cycle, 7);
    chk("R9 hidden advance", dbg_rcnt, 2);
    chk("R9 hidden row", dbg_ref_row, 1);
    chk("R9 data kept en", dout_en, 3);
    chk("R9 data kept", dout, 16'hA5C3);
    put(1,0,0,1,0,0,0);
    put(1,1,1,1,0,0,0);
    chk("R8 off after hidden", dout_en, 0);

    // late write, row 3 col 1
    put(0,1,1,1,1,9'd3,0);
    put(0,0,0,1,1,9'd1,0);
    chk("R11 read before late write", dbg_cycle, 1);
    put(0,0,0,0,1,9'd1,16'hBEEF);
    chk("R6 late write code", dbg_cycle, 3);
    put(0,1,1,1,1,9'd1,0);
    put(1,1,1,1,1,0,0);
    put(0,1,1,1,0,9'd3,0);
    put(0,0,0,1,0,9'd1,0);
    chk("R6 late write stored", dout, 16'hBEEF);
    // read-modify-write in the same row cycle
    put(0,1,1,1,0,9'd1,0);
    put(0,0,0,1,0,9'd1,0);
    chk("R6 rmw read en", dout_en, 3);
    put(0,0,0,1,1,9'd1,0);
    put(0,0,0,0,1,9'd1,16'h0F0F);
    chk("R6 rmw code", dbg_cycle, 4);
    chk("R6 rmw read data kept", dout, 16'hBEEF);
    put(0,1,1,1,1,9'd1,0);
    put(1,1,1,1,1,0,0);
    put(0,1,1,1,0,9'd3,0);
    put(0,0,0,1,0,9'd1,0);
    chk("R6 rmw stored", dout, 16'h0F0F);
    put(0,1,1,1,0,9'd1,0);
    put(1,1,1,1,1,0,0);

    // counter wrap
    for (int i = 0; i < 510; i++) begin
      put(1,0,1,1,1,0,0);
      put(0,0,1,1,1,0,0);
      put(1,0,1,1,1,0,0);
      put(1,1,1,1,1,0,0);
    end
    chk("R3 counter wraps", dbg_rcnt, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule